// File: doc/BRIEF.md
# Alert Line Driver with Alert-Response Answering

This block keeps a device's active-low alert line asserted while a fault needs attention, and lets the device identify itself when the bus master polls the shared alert line. A fault is either a level cause from the limit comparators or an open remote sensor. Either one latches the alert on the next clock edge. This holds even when the comparison was refreshed by a limit rewrite while the device is in standby. Several devices' alert outputs may be wired together on one line, since the output is meant to drive an open-drain pad.

The master polls by reading the alert response address. A device whose alert is asserted acknowledges that read. It then sends its own 7-bit address, followed by a trailing 1. It watches SDA bit by bit and stops sending when another device pulls the line low while it is sending a 1, so the lowest address wins. The alert is released only after a response that completes without losing arbitration, and only if both causes are gone at that moment. Otherwise the master polls again.

SCL and SDA are taken as already synchronised to `clk`, which must be several times faster than SCL. `sda_pull_o` = 1 means "pull SDA low". `alert_n_o` = 0 means the alert is asserted.

Top module: `ara_alert_responder`

## Requirements
- R1: After reset, `alert_n_o` is 1 and `sda_pull_o` is 0.
- R2: A cycle with `alert_cond_i` = 1 drives `alert_n_o` to 0 at the next clock edge, and it stays 0 after the cause drops until a response completes.
- R3: A cycle with `sensor_open_i` = 1 asserts the alert in the same way as R2.
- R4: A read of the response address (address byte 8'h19, that is 7'b0001100 with R/W = 1) while `alert_n_o` is 1 gets no acknowledge, and SDA is not pulled during that transaction.
- R5: A response-address read while `alert_n_o` is 0 is acknowledged on the 9th clock. The block then sends 8'h99 MSB first, which is device address 7'h4C followed by a 1, and releases SDA for the master's acknowledge bit.
- R6: When the last response bit is sent without losing arbitration and both causes are 0, `alert_n_o` returns to 1.
- R7: When a cause is still 1 at the completion described in R6, `alert_n_o` stays 0.
- R8: If SDA is sampled low at an SCL rise while the block is sending a 1, the block drives nothing more in that transaction and keeps the alert asserted. A later response-address read is answered again. While the block is sending a 0 it does not back off.
- R9: Any address byte other than 8'h19 gets no acknowledge, and SDA is not pulled until the next start condition.
- R10: `sda_pull_o` rises only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA line level |
| alert_cond_i | input | 1 | Level: a measurement is out of limits |
| sensor_open_i | input | 1 | Level: the remote sensor is open |
| sda_pull_o | output | 1 | 1 = pull SDA low |
| alert_n_o | output | 1 | Active-low alert, to the open-drain pad |

## Verification
Alert latching is visible one clock after a cause is presented, so the bench drives a cause on a falling edge and samples on the next falling edge. Bus results are due within one clock of an SCL edge. The bench holds every SCL phase for several clocks and samples SDA in the middle of the high phase. It reads the alert state only after the whole transaction, including the stop condition, has finished. A sweep sends all 256 address bytes with the alert asserted, and separate transactions model a second device, one with a lower address and one with a higher address.

// File: rtl/ara_pkg.sv
package ara_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_SEND,
        ST_DONE
    } resp_state_e;

    typedef struct packed {
        resp_state_e st;
        logic [3:0]  cnt;
        logic [7:0]  shreg;
        logic        drive;
    } resp_fsm_s;
endpackage

// File: rtl/smb_edge_detect.sv
module smb_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } lines_s;

    lines_s lines_d, lines_q;

    always_comb begin
        lines_d.scl = scl_i;
        lines_d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lines_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            lines_q <= lines_d;
        end
    end

    assign scl_rise_o = scl_i & ~lines_q.scl;
    assign scl_fall_o = ~scl_i & lines_q.scl;
    assign start_o    = scl_i & lines_q.scl & lines_q.sda & ~sda_i;
    assign stop_o     = scl_i & lines_q.scl & ~lines_q.sda & sda_i;
endmodule

// File: rtl/ara_fsm.sv
module ara_fsm
    import ara_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h4C,
    parameter logic [6:0] ARA_ADDR = 7'h0C
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic scl_rise_i,
    input  logic scl_fall_i,
    input  logic start_i,
    input  logic stop_i,
    input  logic alert_active_i,
    output logic sda_pull_o,
    output logic resp_done_o
);
    localparam logic [7:0] RESP_BYTE  = {DEV_ADDR, 1'b1};
    localparam logic [7:0] MATCH_BYTE = {ARA_ADDR, 1'b1};
    localparam logic [3:0] BYTE_BITS  = 4'd8;

    resp_fsm_s fsm_d, fsm_q;
    logic      done_d;

    always_comb begin
        fsm_d  = fsm_q;
        done_d = 1'b0;
        if (stop_i) begin
            fsm_d.st    = ST_IDLE;
            fsm_d.drive = 1'b0;
        end else if (start_i) begin
            fsm_d.st    = ST_ADDR;
            fsm_d.cnt   = '0;
            fsm_d.drive = 1'b0;
        end else begin
            case (fsm_q.st)
                ST_ADDR: begin
                    if (scl_rise_i) begin
                        fsm_d.shreg = {fsm_q.shreg[6:0], sda_i};
                        fsm_d.cnt   = fsm_q.cnt + 4'd1;
                    end else if (scl_fall_i && fsm_q.cnt == BYTE_BITS) begin
                        if (fsm_q.shreg == MATCH_BYTE && alert_active_i) begin
                            fsm_d.st    = ST_ACK;
                            fsm_d.drive = 1'b1;
                        end else begin
                            fsm_d.st = ST_DONE;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall_i) begin
                        fsm_d.st    = ST_SEND;
                        fsm_d.cnt   = '0;
                        fsm_d.drive = ~RESP_BYTE[7];
                    end
                end
                ST_SEND: begin
                    if (scl_rise_i) begin
                        if (!fsm_q.drive && !sda_i) begin
                            fsm_d.st = ST_DONE;
                        end else begin
                            fsm_d.cnt = fsm_q.cnt + 4'd1;
                            if (fsm_q.cnt == BYTE_BITS - 4'd1) begin
                                done_d   = 1'b1;
                                fsm_d.st = ST_DONE;
                            end
                        end
                    end else if (scl_fall_i) begin
                        fsm_d.drive = ~RESP_BYTE[3'd7 - fsm_q.cnt[2:0]];
                    end
                end
                ST_DONE: begin
                    if (scl_fall_i) begin
                        fsm_d.drive = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{st: ST_IDLE, cnt: '0, shreg: '0, drive: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign sda_pull_o  = fsm_q.drive;
    assign resp_done_o = done_d;

    assert_drive_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_i);

    assert_backoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_SEND && scl_rise_i && !fsm_q.drive && !sda_i && !start_i && !stop_i)
        |=> (fsm_q.st != ST_SEND && !resp_done_o));

    assert_no_ack_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_ADDR && scl_fall_i && fsm_q.cnt == BYTE_BITS && !alert_active_i
         && !start_i && !stop_i) |=> !sda_pull_o);
endmodule

// File: rtl/alert_latch.sv
module alert_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic alert_cond_i,
    input  logic sensor_open_i,
    input  logic resp_done_i,
    output logic alert_o
);
    logic alert_d, alert_q;
    logic cause;

    always_comb begin
        cause   = alert_cond_i | sensor_open_i;
        alert_d = cause | (alert_q & ~resp_done_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alert_q <= 1'b0;
        end else begin
            alert_q <= alert_d;
        end
    end

    assign alert_o = alert_q;

    assert_latch_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_cond_i || sensor_open_i) |=> alert_o);

    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_o && resp_done_i && !alert_cond_i && !sensor_open_i) |=> !alert_o);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_o && !resp_done_i) |=> alert_o);
endmodule

// File: rtl/ara_alert_responder.sv
module ara_alert_responder #(
    parameter logic [6:0] DEV_ADDR = 7'h4C,
    parameter logic [6:0] ARA_ADDR = 7'h0C
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic alert_cond_i,
    input  logic sensor_open_i,
    output logic sda_pull_o,
    output logic alert_n_o
);
    logic scl_rise, scl_fall, start_ev, stop_ev;
    logic alert_active, resp_done;

    smb_edge_detect u_edges (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    ara_fsm #(
        .DEV_ADDR (DEV_ADDR),
        .ARA_ADDR (ARA_ADDR)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .scl_i          (scl_i),
        .sda_i          (sda_i),
        .scl_rise_i     (scl_rise),
        .scl_fall_i     (scl_fall),
        .start_i        (start_ev),
        .stop_i         (stop_ev),
        .alert_active_i (alert_active),
        .sda_pull_o     (sda_pull_o),
        .resp_done_o    (resp_done)
    );

    alert_latch u_latch (
        .clk           (clk),
        .rst_n         (rst_n),
        .alert_cond_i  (alert_cond_i),
        .sensor_open_i (sensor_open_i),
        .resp_done_i   (resp_done),
        .alert_o       (alert_active)
    );

    assign alert_n_o = ~alert_active;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (alert_n_o && !sda_pull_o));
endmodule

// File: tb/ara_alert_responder_test.sv
module ara_alert_responder_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic msda = 1'b1;
    logic rival = 1'b0;
    logic cond = 1'b0;
    logic sopen = 1'b0;
    logic sda_pull, alert_n, line;
    logic track = 1'b0;
    logic pulled = 1'b0;
    int   checks = 0;
    int   fails = 0;
    int   cycles = 0;

    always #10 clk = ~clk;

    assign line = msda & ~sda_pull & ~rival;

    ara_alert_responder uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl),
        .sda_i         (line),
        .alert_cond_i  (cond),
        .sensor_open_i (sopen),
        .sda_pull_o    (sda_pull),
        .alert_n_o     (alert_n)
    );

    always @(negedge clk) if (track && sda_pull) pulled = 1'b1;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        msda = 1'b1; scl = 1'b1; wait_n(3);
        msda = 1'b0; wait_n(3);
        scl = 1'b0; wait_n(2);
    endtask

    task automatic bus_stop();
        msda = 1'b0; wait_n(2);
        scl = 1'b1; wait_n(3);
        msda = 1'b1; wait_n(3);
    endtask

    task automatic bus_bit(input logic m, input logic rv, output logic seen);
        msda = m; rival = rv; wait_n(3);
        scl = 1'b1; wait_n(2);
        seen = line; wait_n(2);
        scl = 1'b0; wait_n(1);
        rival = 1'b0;
    endtask

    task automatic txn(input logic [7:0] abyte, input logic rv_en, input logic [7:0] rv_byte,
                       output logic acked, output logic [7:0] rd);
        logic s;
        rd = 8'h00;
        pulled = 1'b0;
        track = 1'b1;
        bus_start();
        for (int i = 0; i < 8; i++) bus_bit(abyte[7-i], 1'b0, s);
        bus_bit(1'b1, rv_en, s);
        acked = ~s;
        if (acked) begin
            for (int i = 0; i < 8; i++) begin
                bus_bit(1'b1, rv_en & ~rv_byte[7-i], s);
                rd[7-i] = s;
            end
            bus_bit(1'b1, 1'b0, s);
        end
        bus_stop();
        track = 1'b0;
        wait_n(2);
    endtask

    initial begin
        logic       ack;
        logic [7:0] rd;
        wait_n(3);
        check("R1 alert_n", {7'd0, alert_n}, 8'd1);
        check("R1 pull", {7'd0, sda_pull}, 8'd0);
        rst_n = 1'b1;
        wait_n(2);
        check("R1 alert_n after release", {7'd0, alert_n}, 8'd1);

        // R4: response-address read while idle gets no ack
        txn(8'h19, 1'b0, 8'h00, ack, rd);
        check("R4 ack", {7'd0, ack}, 8'd0);
        check("R4 pull", {7'd0, pulled}, 8'd0);

        // R2: one-cycle cause latches on the next edge
        cond = 1'b1; wait_n(1); cond = 1'b0;
        check("R2 asserted next cycle", {7'd0, alert_n}, 8'd0);
        wait_n(5);
        check("R2 held after cause drops", {7'd0, alert_n}, 8'd0);

        // R5 + R6: answered and released
        txn(8'h19, 1'b0, 8'h00, ack, rd);
        check("R5 ack", {7'd0, ack}, 8'd1);
        check("R5 address byte", rd, 8'h99);
        check("R6 released", {7'd0, alert_n}, 8'd1);

        // R3 + R7: sensor open stays present through the response
        sopen = 1'b1; wait_n(1);
        check("R3 asserted next cycle", {7'd0, alert_n}, 8'd0);
        txn(8'h19, 1'b0, 8'h00, ack, rd);
        check("R7 ack", {7'd0, ack}, 8'd1);
        check("R7 address byte", rd, 8'h99);
        check("R7 held", {7'd0, alert_n}, 8'd0);
        sopen = 1'b0;
        txn(8'h19, 1'b0, 8'h00, ack, rd);
        check("R6 address byte", rd, 8'h99);
        check("R6 released after cause gone", {7'd0, alert_n}, 8'd1);

        // R8: a lower-address rival wins, the block stays asserted
        cond = 1'b1; wait_n(1); cond = 1'b0;
        txn(8'h19, 1'b1, 8'h31, ack, rd);
        check("R8 rival byte on bus", rd, 8'h31);
        check("R8 alert kept", {7'd0, alert_n}, 8'd0);
        txn(8'h19, 1'b0, 8'h00, ack, rd);
        check("R8 later answer", rd, 8'h99);
        check("R8 released after later win", {7'd0, alert_n}, 8'd1);

        // R8: a higher-address rival loses, the block completes
        cond = 1'b1; wait_n(1); cond = 1'b0;
        txn(8'h19, 1'b1, 8'h9B, ack, rd);
        check("R8 win against higher rival", rd, 8'h99);
        check("R8 released on win", {7'd0, alert_n}, 8'd1);

        // R9: sweep every address byte with the alert held asserted
        cond = 1'b1;
        for (int b = 0; b < 256; b++) begin
            txn(b[7:0], 1'b0, 8'h00, ack, rd);
            if (b == 8'h19) begin
                check("R9 match ack", {7'd0, ack}, 8'd1);
                check("R9 match byte", rd, 8'h99);
            end else begin
                check("R9 no ack/pull", {6'd0, ack, pulled}, 8'd0);
            end
        end
        check("R9 alert held by cause", {7'd0, alert_n}, 8'd0);
        cond = 1'b0;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule